// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out vector configuration instructions that pick a new element width and register-grouping multiplier and set the active vector length. Each strobe presents three things: a requested length taken from a scalar register operand, flags that say whether the source and destination register specifiers are register zero, and the encoded width and multiplier. The unit holds the active vector length and the vector type state, which includes an illegal-configuration flag. It drives this state to the rest of the vector unit. It also reports whether the destination register must be written back and with what value.

The maximum vector length follows from the hardware register length, the multiplier and the element width. The requested length is clamped to that maximum. In one special form both register specifiers are zero. That form keeps the current vector length and changes only the type. It is legal only if the maximum length stays the same and the state was legal before. In every other case the unit marks the configuration illegal.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is asserted and after it is released, the illegal flag is 1, the vector length is 0, the width and multiplier fields are 0, and no write-back is signalled.
- R2: The width code w (0..3) means 8<<w bits. The multiplier code m is a signed 3-bit value: 0..3 mean ×1, ×2, ×4, ×8, and 7, 6, 5 mean ×1/2, ×1/4, ×1/8. The maximum length is VLEN·multiplier / width bits.
- R3: The configuration is illegal, and the illegal flag is set, if any of these holds: the width code is above 3, the width is wider than ELEN, the multiplier code is 4, or the maximum length works out below 1.
- R4: When the source specifier is not zero, the new length is min(requested, maximum). Write-back is signalled exactly when the destination specifier is not zero.
- R5: When the source specifier is zero and the destination is not, the new length is the maximum and write-back is signalled.
- R6: When both specifiers are zero, the prior state is legal and the new maximum equals the current maximum, the length keeps its value, the type takes the new fields, and no write-back is signalled.
- R7: When both specifiers are zero and the new maximum differs from the current one, the illegal flag is set.
- R8: When both specifiers are zero and the illegal flag was already 1, the flag is set again, whatever the new ratio is.
- R9: Whenever the illegal flag is set, the length, width field and multiplier field are all 0.
- R10: Results appear in the cycle after the strobe. Without a strobe the state holds and write-back stays low.
- R11: When write-back is signalled, its data equals the new vector length, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Strobe: apply one configuration instruction |
| rs1_is_x0 | input | 1 | Source register specifier is register zero |
| rd_is_x0 | input | 1 | Destination register specifier is register zero |
| avl_i | input | XLEN | Requested length from the source operand |
| sew_i | input | 3 | Requested element width code |
| lmul_i | input | 3 | Requested multiplier code |
| vl_o | output | VLW | Active vector length |
| ill_o | output | 1 | Illegal-configuration flag |
| sew_o | output | 3 | Current element width code |
| lmul_o | output | 3 | Current multiplier code |
| rd_we_o | output | 1 | Destination write-back strobe |
| rd_data_o | output | XLEN | Destination write-back value |

## Verification
The hardest case to reach is the both-zero form when the type is already illegal but the new ratio matches the maximum that the zeroed fields imply. Only the prior flag makes that case reserved. The bench reaches it by first applying an illegal encoding through a normal instruction and then issuing the both-zero form with every one of the 64 codes. It does the same from each of the 64 prior configurations. Each prior configuration is loaded with a small requested length, so a length that is kept can be told apart from one recomputed to the maximum.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef struct packed {
    logic       ill;
    logic [2:0] sew;
    logic [2:0] lmul;
  } vtype_t;

  typedef enum logic [1:0] {
    FORM_AVL  = 2'd0,
    FORM_MAX  = 2'd1,
    FORM_KEEP = 2'd2
  } form_e;

  localparam logic [2:0] LMUL_RSVD = 3'b100;

endpackage

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  localparam int LOG2VLEN = $clog2(VLEN),
  localparam int LOG2ELEN = $clog2(ELEN),
  localparam int VLW = LOG2VLEN + 1
) (
  input  logic [2:0]     sew_i,
  input  logic [2:0]     lmul_i,
  output logic           legal_o,
  output logic [VLW-1:0] vlmax_o
);
  import vcfg_pkg::*;

  logic signed [7:0] expo;
  logic              sew_ok;

  always_comb begin
    expo = 8'(LOG2VLEN - 3) - {5'd0, sew_i} + {{5{lmul_i[2]}}, lmul_i};
    sew_ok = ({5'd0, sew_i} <= 8'(LOG2ELEN - 3));
    legal_o = sew_ok && (lmul_i != LMUL_RSVD) && (expo >= 8'sd0);
    if (expo >= 8'sd0) vlmax_o = VLW'(1) << expo[6:0];
    else               vlmax_o = '0;
  end

endmodule

// File: rtl/vcfg_next.sv
module vcfg_next #(
  parameter int XLEN = 32,
  parameter int VLW  = 8
) (
  input  vcfg_pkg::form_e  form_i,
  input  logic [XLEN-1:0]  avl_i,
  input  logic [2:0]       sew_i,
  input  logic [2:0]       lmul_i,
  input  logic             new_legal_i,
  input  logic [VLW-1:0]   new_vlmax_i,
  input  logic [VLW-1:0]   cur_vlmax_i,
  input  logic [VLW-1:0]   cur_vl_i,
  input  logic             cur_ill_i,
  output vcfg_pkg::vtype_t vtype_o,
  output logic [VLW-1:0]   vl_o
);
  import vcfg_pkg::*;

  logic           reserved;
  logic [VLW-1:0] vl_raw;

  always_comb begin
    reserved = 1'b0;
    unique case (form_i)
      FORM_AVL: vl_raw = (avl_i > XLEN'(new_vlmax_i)) ? new_vlmax_i : avl_i[VLW-1:0];
      FORM_MAX: vl_raw = new_vlmax_i;
      default: begin
        vl_raw   = cur_vl_i;
        reserved = cur_ill_i || (new_vlmax_i != cur_vlmax_i);
      end
    endcase

    if (!new_legal_i || reserved) begin
      vtype_o = '{ill: 1'b1, sew: 3'd0, lmul: 3'd0};
      vl_o    = '0;
    end else begin
      vtype_o = '{ill: 1'b0, sew: sew_i, lmul: lmul_i};
      vl_o    = vl_raw;
    end
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 32,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic            rs1_is_x0,
  input  logic            rd_is_x0,
  input  logic [XLEN-1:0] avl_i,
  input  logic [2:0]      sew_i,
  input  logic [2:0]      lmul_i,
  output logic [VLW-1:0]  vl_o,
  output logic            ill_o,
  output logic [2:0]      sew_o,
  output logic [2:0]      lmul_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] rd_data_o
);
  import vcfg_pkg::*;

  localparam int NSRC = 2;  // 0: requested code, 1: current state

  vtype_t         vtype_q, vtype_d;
  logic [VLW-1:0] vl_q, vl_d;
  logic           we_q, we_d;
  logic [XLEN-1:0] wdata_q;
  form_e          form;

  logic [NSRC-1:0][2:0]     src_sew, src_lmul;
  logic [NSRC-1:0]          src_legal;
  logic [NSRC-1:0][VLW-1:0] src_vlmax;

  assign src_sew[0]  = sew_i;
  assign src_lmul[0] = lmul_i;
  assign src_sew[1]  = vtype_q.sew;
  assign src_lmul[1] = vtype_q.lmul;

  for (genvar g = 0; g < NSRC; g++) begin : g_vlmax
    vcfg_vlmax #(.VLEN(VLEN), .ELEN(ELEN)) u_vlmax (
      .sew_i  (src_sew[g]),
      .lmul_i (src_lmul[g]),
      .legal_o(src_legal[g]),
      .vlmax_o(src_vlmax[g])
    );
  end

  always_comb begin
    if (!rs1_is_x0)     form = FORM_AVL;
    else if (!rd_is_x0) form = FORM_MAX;
    else                form = FORM_KEEP;
    we_d = cfg_valid && !rd_is_x0;
  end

  vcfg_next #(.XLEN(XLEN), .VLW(VLW)) u_next (
    .form_i     (form),
    .avl_i      (avl_i),
    .sew_i      (sew_i),
    .lmul_i     (lmul_i),
    .new_legal_i(src_legal[0]),
    .new_vlmax_i(src_vlmax[0]),
    .cur_vlmax_i(src_vlmax[1]),
    .cur_vl_i   (vl_q),
    .cur_ill_i  (vtype_q.ill),
    .vtype_o    (vtype_d),
    .vl_o       (vl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtype_q <= '{ill: 1'b1, sew: 3'd0, lmul: 3'd0};
      vl_q    <= '0;
      wdata_q <= '0;
    end else if (cfg_valid) begin
      vtype_q <= vtype_d;
      vl_q    <= vl_d;
      wdata_q <= XLEN'(vl_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  assign vl_o      = vl_q;
  assign ill_o     = vtype_q.ill;
  assign sew_o     = vtype_q.sew;
  assign lmul_o    = vtype_q.lmul;
  assign rd_we_o   = we_q;
  assign rd_data_o = wdata_q;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN = 32,
  parameter int VLW  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_valid,
  input logic            rs1_is_x0,
  input logic            rd_is_x0,
  input logic [XLEN-1:0] avl_i,
  input logic [VLW-1:0]  vl_o,
  input logic            ill_o,
  input logic [2:0]      sew_o,
  input logic [2:0]      lmul_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] rd_data_o
);

  AST_ILL_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ill_o |-> (vl_o == '0 && sew_o == 3'd0 && lmul_o == 3'd0)); // R9

  AST_KEEP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && rs1_is_x0 && rd_is_x0) |=> !rd_we_o); // R6

  AST_PRIOR_ILL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && rs1_is_x0 && rd_is_x0 && ill_o) |=> ill_o); // R8

  AST_KEEP_VL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && rs1_is_x0 && rd_is_x0) |=> (ill_o || vl_o == $past(vl_o))); // R6

  AST_AVL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !rs1_is_x0) |=> (XLEN'(vl_o) <= $past(avl_i))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> ($stable(vl_o) && $stable(ill_o) && $stable(sew_o)
                    && $stable(lmul_o) && !rd_we_o)); // R10

  AST_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (rd_data_o == XLEN'(vl_o))); // R11

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLW(VLW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_valid(cfg_valid),
  .rs1_is_x0(rs1_is_x0),
  .rd_is_x0 (rd_is_x0),
  .avl_i    (avl_i),
  .vl_o     (vl_o),
  .ill_o    (ill_o),
  .sew_o    (sew_o),
  .lmul_o   (lmul_o),
  .rd_we_o  (rd_we_o),
  .rd_data_o(rd_data_o)
);

// File: tb/tb_vcfg_unit.sv
`timescale 1ns/1ps
module tb_vcfg_unit;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int XLEN = 32;
  localparam int VLW  = $clog2(VLEN) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_valid, rs1_is_x0, rd_is_x0;
  logic [XLEN-1:0] avl_i;
  logic [2:0] sew_i, lmul_i;
  logic [VLW-1:0] vl_o;
  logic ill_o, rd_we_o;
  logic [2:0] sew_o, lmul_o;
  logic [XLEN-1:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_vl, m_sew, m_lmul;
  bit m_ill;

  always #2.5 clk = ~clk;

  vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) dut (.*);

  function automatic bit ref_legal(int s, int l);
    int w, q;
    if (s > 3 || l == 4) return 0;
    w = 8 << s;
    if (w > ELEN) return 0;
    q = (l < 4) ? (VLEN * (1 << l)) / w : VLEN / (w * (1 << (8 - l)));
    return q >= 1;
  endfunction

  function automatic int ref_vlmax(int s, int l);
    int w;
    w = 8 << (s & 3);
    if (l < 4) return (VLEN * (1 << l)) / w;
    return VLEN / (w * (1 << (8 - l)));
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(bit r1z, bit rdz, int avl, int s, int l);
    bit leg, res, e_ill, e_we;
    int vm, e_vl, e_sew, e_lmul;
    string tag;
    leg = ref_legal(s, l);
    vm  = leg ? ref_vlmax(s, l) : 0;
    res = 0;
    if (!r1z) begin
      e_vl = (avl > vm) ? vm : avl; e_we = !rdz; tag = "R4";
    end else if (!rdz) begin
      e_vl = vm; e_we = 1; tag = "R2/R5";
    end else begin
      e_vl = m_vl; e_we = 0;
      res = m_ill || (vm != ref_vlmax(m_sew, m_lmul));
      tag = m_ill ? "R8" : (leg && vm != ref_vlmax(m_sew, m_lmul)) ? "R7" : "R6";
    end
    if (!leg && !(r1z && rdz)) tag = "R3";
    e_ill = !leg || res;
    e_sew = s; e_lmul = l;
    if (e_ill) begin e_vl = 0; e_sew = 0; e_lmul = 0; end

    cfg_valid = 1; rs1_is_x0 = r1z; rd_is_x0 = rdz;
    avl_i = XLEN'(avl); sew_i = 3'(s); lmul_i = 3'(l);
    @(negedge clk);
    cfg_valid = 0;
    check(int'(vl_o) == e_vl, tag, "vl", int'(vl_o), e_vl);
    check(ill_o == e_ill, tag, "ill", int'(ill_o), int'(e_ill));
    check(int'(sew_o) == e_sew && int'(lmul_o) == e_lmul, tag, "sew*8+lmul",
          int'(sew_o) * 8 + int'(lmul_o), e_sew * 8 + e_lmul);
    check(rd_we_o == e_we, tag, "rd_we", int'(rd_we_o), int'(e_we));
    if (e_ill)
      check(vl_o == '0 && sew_o == 3'd0 && lmul_o == 3'd0, "R9", "zeroed",
            int'(vl_o), 0);
    if (e_we)
      check(int'(rd_data_o) == e_vl, "R11", "rd_data", int'(rd_data_o), e_vl);
    m_vl = e_vl; m_sew = e_sew; m_lmul = e_lmul; m_ill = e_ill;
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(int'(vl_o) == m_vl && ill_o == m_ill && int'(sew_o) == m_sew
          && int'(lmul_o) == m_lmul, "R10", "hold", int'(vl_o), m_vl);
    check(!rd_we_o, "R10", "rd_we idle", int'(rd_we_o), 0);
  endtask

  initial begin
    int avls[6];
    rst_n = 0; cfg_valid = 0; rs1_is_x0 = 0; rd_is_x0 = 0;
    avl_i = '0; sew_i = '0; lmul_i = '0;
    repeat (3) @(negedge clk);
    check(ill_o && vl_o == '0 && sew_o == 3'd0 && lmul_o == 3'd0 && !rd_we_o,
          "R1", "reset state", int'(vl_o), 0);
    rst_n = 1;
    @(negedge clk);
    check(ill_o && vl_o == '0 && !rd_we_o, "R1", "after release",
          int'(ill_o), 1);
    m_vl = 0; m_sew = 0; m_lmul = 0; m_ill = 1;

    // x0/x0 straight out of reset: prior illegal state
    apply(1, 1, 0, 0, 0);

    // requested-length and maximum forms over every code
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 8; l++) begin
        int vm;
        vm = ref_vlmax(s, l);
        avls[0] = 0; avls[1] = 1; avls[2] = (vm > 0) ? vm - 1 : 0;
        avls[3] = vm; avls[4] = vm + 1; avls[5] = 32'h7fff_fff0;
        for (int a = 0; a < 6; a++) apply(0, a[0], avls[a], s, l);
        apply(1, 0, 0, s, l);
      end
    end
    idle_check();

    // keep-length form from every prior configuration to every new one
    for (int p = 0; p < 64; p++) begin
      for (int n = 0; n < 64; n++) begin
        apply(0, 1, 3, p >> 3, p & 7);
        apply(1, 1, 12345, n >> 3, n & 7);
      end
    end
    idle_check();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule